// File: doc/BRIEF.md
# Configurable-Sense Interrupt Collector

This block gathers 51 external interrupt lines and drives two processor requests: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each line can be set up on its own. Software picks level or edge detection, single or dual edge, and the active polarity. It also sets an enable mask, a route to IRQ or FIQ, and a software trigger. Every input passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. A detected edge stays latched until software clears it.

Software uses a small register port with a request/acknowledge handshake. A two-state machine runs the port. In `ST_IDLE` it waits for `req`. The transition *accept* (`ST_IDLE` to `ST_DONE`) performs the write or captures the read data. In `ST_DONE` it raises `ack` for one cycle. The transition *retire* (`ST_DONE` to `ST_IDLE`) then follows unconditionally. A second address window mirrors the old legacy layout. Accesses there are acknowledged but have no effect.

Top module: `vic_top`

## Requirements
- R1: After reset, `irq_o`, `fiq_o` and `ack` are 0, and every readable register reads 0.
- R2: With sense=0, dual=0 and polarity=1, a rising input latches the line's raw bit. The bit stays set after the input falls and is removed only by writing 1 to the clear pair. A falling input does not set the bit.
- R3: With sense=0, dual=0 and polarity=0, only a falling input latches the raw bit. A rising input does not set it.
- R4: With sense=0 and dual=1, both a rising and a falling input latch the raw bit, whatever the polarity.
- R5: With sense=1, the raw bit equals the input when polarity=1 and the inverted input when polarity=0. A clear write does not drop it while the input is active.
- R6: Select=1 routes a line to FIQ and select=0 routes it to IRQ. `irq_o` is the registered OR of raw&enable&~select, and `fiq_o` is the registered OR of raw&enable&select.
- R7: Writing 1s to the enable-set pair sets enable bits. Writing 1s to the enable-clear pair clears them. Zeros change nothing. A raw bit whose line is disabled reaches neither output. The enable pair reads back the current mask.
- R8: A 1 in the soft-trigger pair raises the line's raw bit with no input activity. A clear write removes both the soft-trigger bit and any edge latch.
- R9: Accesses with `addr[7]`=1 (the legacy window) are acknowledged, read 0, and change no state.
- R10: A request seen in `ST_IDLE` is answered by `ack` high on the next cycle, for exactly one cycle.
- R11: Register pairs sit at byte address 8*p, with the low word (bits 31:0) at +0 and the high word (bits 63:32) at +4. The pair numbers are: p=0 IRQ status, 1 FIQ status, 2 raw, 3 select, 4 enable, 5 enable-set, 6 enable-clear, 7 sense, 8 dual, 9 polarity, 10 soft trigger, 11 clear. Bits above line 50 read 0, and the set, clear and enable-clear pairs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 51 | Interrupt source lines (asynchronous) |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address; bit 7 selects the legacy window |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access complete, one cycle |
| rdata | output | 32 | Read data, valid while `ack` is high |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
An input edge passes through two synchronizer flops, the history flop and latch, and the output register. It reaches `irq_o`/`fiq_o` at the fourth rising clock after the change, while a level input needs three. A clear, trigger or enable write takes effect at the accepting edge and shows on the outputs one edge later. Read data and `ack` appear one edge after acceptance. The bench drives on falling edges and samples only after waiting at least one full cycle beyond each of these delays, so that every check lands on settled values.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VEC_W = 64;

    // register pair numbers (byte address = 8 * pair, +4 for the high word)
    localparam logic [3:0] PR_IRQ   = 4'd0;
    localparam logic [3:0] PR_FIQ   = 4'd1;
    localparam logic [3:0] PR_RAW   = 4'd2;
    localparam logic [3:0] PR_SEL   = 4'd3;
    localparam logic [3:0] PR_EN    = 4'd4;
    localparam logic [3:0] PR_ENSET = 4'd5;
    localparam logic [3:0] PR_ENCLR = 4'd6;
    localparam logic [3:0] PR_SENSE = 4'd7;
    localparam logic [3:0] PR_DUAL  = 4'd8;
    localparam logic [3:0] PR_POL   = 4'd9;
    localparam logic [3:0] PR_SWT   = 4'd10;
    localparam logic [3:0] PR_CLR   = 4'd11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bus_st_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W = 51
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/vic_detect.sv
module vic_detect #(
    parameter int N = 51
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] s_i,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] dual_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] hw_raw_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;
        logic lat_q;
        logic rise;
        logic fall;
        logic hit;

        assign rise = s_i[i] & ~prev_q;
        assign fall = ~s_i[i] & prev_q;
        assign hit  = dual_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                lat_q  <= 1'b0;
            end else begin
                prev_q <= s_i[i];
                if (sense_i[i]) lat_q <= 1'b0;
                else            lat_q <= (lat_q & ~clr_i[i]) | hit;
            end
        end

        assign hw_raw_o[i] = sense_i[i] ? ~(s_i[i] ^ pol_i[i]) : lat_q;
    end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int N  = 51,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  hw_raw_i,
    output logic [N-1:0]  sense_o,
    output logic [N-1:0]  dual_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  sel_o,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  raw_o,
    output logic [N-1:0]  clr_o,
    output logic          irq_o,
    output logic          fiq_o
);
    localparam int PAD = VEC_W - N;

    bus_st_t state_q, state_d;
    logic [N-1:0] sel_q, en_q, sense_q, dual_q, pol_q, swt_q;
    logic [DW-1:0] rdata_q;
    logic irq_q, fiq_q;

    logic        legacy, half, accept, wr_ok;
    logic [3:0]  pair;
    logic [VEC_W-1:0] wide_d, wide_m, rd_vec;
    logic [N-1:0] wd, wm, raw_all;
    logic        addr_unused, wide_unused;

    assign legacy = addr[AW-1];
    assign half   = addr[2];
    assign pair   = addr[6:3];
    assign addr_unused = ^addr[1:0];
    assign accept = (state_q == ST_IDLE) && req;
    assign wr_ok  = accept && we && !legacy;

    assign wide_d = half ? {wdata, {DW{1'b0}}} : {{DW{1'b0}}, wdata};
    assign wide_m = half ? {{DW{1'b1}}, {DW{1'b0}}} : {{DW{1'b0}}, {DW{1'b1}}};
    assign wd = wide_d[N-1:0];
    assign wm = wide_m[N-1:0];
    assign wide_unused = ^{wide_d[VEC_W-1:N], wide_m[VEC_W-1:N]};

    assign raw_all = hw_raw_i | swt_q;
    assign clr_o   = (wr_ok && pair == PR_CLR) ? wd : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_DONE;   // accept
            ST_DONE: state_d = ST_IDLE;            // retire
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            en_q    <= '0;
            sense_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            swt_q   <= '0;
        end else if (wr_ok) begin
            case (pair)
                PR_SEL:   sel_q   <= (sel_q & ~wm) | wd;
                PR_ENSET: en_q    <= en_q | wd;
                PR_ENCLR: en_q    <= en_q & ~wd;
                PR_SENSE: sense_q <= (sense_q & ~wm) | wd;
                PR_DUAL:  dual_q  <= (dual_q & ~wm) | wd;
                PR_POL:   pol_q   <= (pol_q & ~wm) | wd;
                PR_SWT:   swt_q   <= (swt_q & ~wm) | wd;
                PR_CLR:   swt_q   <= swt_q & ~wd;
                default:  ;
            endcase
        end
    end

    // read selection
    always_comb begin
        rd_vec = '0;
        case (pair)
            PR_IRQ:   rd_vec = {{PAD{1'b0}}, raw_all & en_q & ~sel_q};
            PR_FIQ:   rd_vec = {{PAD{1'b0}}, raw_all & en_q & sel_q};
            PR_RAW:   rd_vec = {{PAD{1'b0}}, raw_all};
            PR_SEL:   rd_vec = {{PAD{1'b0}}, sel_q};
            PR_EN:    rd_vec = {{PAD{1'b0}}, en_q};
            PR_SENSE: rd_vec = {{PAD{1'b0}}, sense_q};
            PR_DUAL:  rd_vec = {{PAD{1'b0}}, dual_q};
            PR_POL:   rd_vec = {{PAD{1'b0}}, pol_q};
            PR_SWT:   rd_vec = {{PAD{1'b0}}, swt_q};
            default:  rd_vec = '0;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
            fiq_q   <= 1'b0;
        end else begin
            if (accept) begin
                if (legacy)    rdata_q <= '0;
                else if (half) rdata_q <= rd_vec[VEC_W-1:DW];
                else           rdata_q <= rd_vec[DW-1:0];
            end
            irq_q <= |(raw_all & en_q & ~sel_q);
            fiq_q <= |(raw_all & en_q & sel_q);
        end
    end

    assign ack     = (state_q == ST_DONE);
    assign rdata   = rdata_q;
    assign irq_o   = irq_q;
    assign fiq_o   = fiq_q;
    assign sense_o = sense_q;
    assign dual_o  = dual_q;
    assign pol_o   = pol_q;
    assign sel_o   = sel_q;
    assign en_o    = en_q;
    assign raw_o   = raw_all;
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NUM_SRC = 51,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic               ack,
    output logic [DW-1:0]      rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    logic [NUM_SRC-1:0] s_sync, hw_raw, sense_all, dual_all, pol_all;
    logic [NUM_SRC-1:0] sel_all, en_all, raw_all, clr_all;

    vic_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(s_sync)
    );

    vic_detect #(.N(NUM_SRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .s_i(s_sync),
        .sense_i(sense_all), .dual_i(dual_all), .pol_i(pol_all),
        .clr_i(clr_all), .hw_raw_o(hw_raw)
    );

    vic_regs #(.N(NUM_SRC), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .hw_raw_i(hw_raw),
        .sense_o(sense_all), .dual_o(dual_all), .pol_o(pol_all),
        .sel_o(sel_all), .en_o(en_all), .raw_o(raw_all), .clr_o(clr_all),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int N  = 51,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [AW-1:0] addr,
    input logic          ack,
    input logic [DW-1:0] rdata,
    input logic          irq_o,
    input logic          fiq_o,
    input logic [N-1:0]  raw_all,
    input logic [N-1:0]  en_all,
    input logic [N-1:0]  sel_all
);
    p_ack_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ack);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_irq_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(raw_all & en_all & ~sel_all))));

    p_fiq_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(raw_all & en_all & sel_all))));

    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |=> (!irq_o && !fiq_o));

    p_legacy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && addr[AW-1]) |=> (rdata == '0 && $stable(en_all)));
endmodule

bind vic_top vic_chk #(.N(NUM_SRC), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ack(ack),
    .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o), .raw_all(raw_all),
    .en_all(en_all), .sel_all(sel_all)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 51;

    localparam logic [7:0] A_IRQ   = 8'h00;
    localparam logic [7:0] A_FIQ   = 8'h08;
    localparam logic [7:0] A_RAW   = 8'h10;
    localparam logic [7:0] A_SEL   = 8'h18;
    localparam logic [7:0] A_EN    = 8'h20;
    localparam logic [7:0] A_ENSET = 8'h28;
    localparam logic [7:0] A_ENCLR = 8'h30;
    localparam logic [7:0] A_SENSE = 8'h38;
    localparam logic [7:0] A_DUAL  = 8'h40;
    localparam logic [7:0] A_POL   = 8'h48;
    localparam logic [7:0] A_SWT   = 8'h50;
    localparam logic [7:0] A_CLR   = 8'h58;
    localparam logic [7:0] HI      = 8'h04;
    localparam logic [7:0] LEG     = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic req = 1'b0;
    logic we = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic ack;
    logic [31:0] rdata;
    logic irq_o, fiq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    vic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic seen);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata; seen = ack;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic s;
        check("R1 irq_o", {31'b0, irq_o}, 32'd0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'd0);
        check("R1 ack", {31'b0, ack}, 32'd0);
        bus_rd(A_RAW, d, s);       check("R1 raw lo", d, 32'd0);
        bus_rd(A_EN | HI, d, s);   check("R1 enable hi", d, 32'd0);
        bus_rd(A_POL, d, s);       check("R1 polarity lo", d, 32'd0);
        // R11: only lines 32..50 exist in the high word
        bus_wr(A_SENSE | HI, 32'hFFFF_FFFF);
        bus_rd(A_SENSE | HI, d, s); check("R11 sense hi width", d, 32'h0007_FFFF);
        bus_wr(A_SENSE | HI, 32'h0);
        bus_rd(A_CLR, d, s);       check("R11 clear reads zero", d, 32'd0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = A_SEL;
        @(negedge clk);
        req = 1'b0;
        check("R10 ack after accept", {31'b0, ack}, 32'd1);
        @(negedge clk);
        check("R10 ack one cycle", {31'b0, ack}, 32'd0);
    endtask

    task automatic t_rise;
        logic [31:0] d; logic s;
        bus_wr(A_POL, 32'h8);
        bus_wr(A_ENSET, 32'h8);
        src_i[3] = 1'b1; idle(5);
        check("R2 rise sets irq", {31'b0, irq_o}, 32'd1);
        check("R6 irq route no fiq", {31'b0, fiq_o}, 32'd0);
        src_i[3] = 1'b0; idle(5);
        check("R2 latch holds", {31'b0, irq_o}, 32'd1);
        bus_rd(A_IRQ, d, s); check("R2 irq status lo", d, 32'h8);
        bus_wr(A_CLR, 32'h8); idle(1);
        check("R2 clear drops irq", {31'b0, irq_o}, 32'd0);
        src_i[3] = 1'b1; idle(5);
        bus_wr(A_CLR, 32'h8);
        src_i[3] = 1'b0; idle(5);
        check("R2 fall ignored", {31'b0, irq_o}, 32'd0);
        bus_wr(A_ENCLR, 32'h8);
        bus_wr(A_POL, 32'h0);
    endtask

    task automatic t_fall;
        logic [31:0] d; logic s;
        bus_wr(A_SEL | HI, 32'h100);
        bus_wr(A_ENSET | HI, 32'h100);
        src_i[40] = 1'b1; idle(5);
        check("R3 rise ignored", {31'b0, fiq_o}, 32'd0);
        src_i[40] = 1'b0; idle(5);
        check("R3 fall sets fiq", {31'b0, fiq_o}, 32'd1);
        check("R6 fiq route no irq", {31'b0, irq_o}, 32'd0);
        bus_rd(A_FIQ | HI, d, s); check("R6 fiq status hi", d, 32'h100);
        bus_wr(A_CLR | HI, 32'h100); idle(1);
        check("R3 clear drops fiq", {31'b0, fiq_o}, 32'd0);
        bus_wr(A_ENCLR | HI, 32'h100);
        bus_wr(A_SEL | HI, 32'h0);
    endtask

    task automatic t_dual;
        bus_wr(A_DUAL, 32'h20);
        bus_wr(A_ENSET, 32'h20);
        src_i[5] = 1'b1; idle(5);
        check("R4 rise detected", {31'b0, irq_o}, 32'd1);
        bus_wr(A_CLR, 32'h20); idle(1);
        check("R4 cleared", {31'b0, irq_o}, 32'd0);
        src_i[5] = 1'b0; idle(5);
        check("R4 fall detected", {31'b0, irq_o}, 32'd1);
        bus_wr(A_CLR, 32'h20);
        bus_wr(A_ENCLR, 32'h20);
        bus_wr(A_DUAL, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] d; logic s;
        bus_wr(A_SENSE | HI, 32'h4_0000);
        bus_wr(A_POL | HI, 32'h4_0000);
        bus_wr(A_ENSET | HI, 32'h4_0000);
        idle(3);
        check("R5 high level idle", {31'b0, irq_o}, 32'd0);
        src_i[50] = 1'b1; idle(4);
        check("R5 high level asserts", {31'b0, irq_o}, 32'd1);
        bus_wr(A_CLR | HI, 32'h4_0000); idle(1);
        check("R5 clear ignored while active", {31'b0, irq_o}, 32'd1);
        bus_rd(A_RAW | HI, d, s); check("R5 raw hi", d, 32'h4_0000);
        src_i[50] = 1'b0; idle(4);
        check("R5 follows input low", {31'b0, irq_o}, 32'd0);
        bus_wr(A_POL | HI, 32'h0); idle(2);
        check("R5 low-active asserts", {31'b0, irq_o}, 32'd1);
        bus_wr(A_ENCLR | HI, 32'h4_0000);
        bus_wr(A_SENSE | HI, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] d; logic s;
        bus_wr(A_ENSET, 32'h5);
        bus_rd(A_EN, d, s); check("R7 set bits", d, 32'h5);
        bus_wr(A_ENSET, 32'h2);
        bus_rd(A_EN, d, s); check("R7 set keeps others", d, 32'h7);
        bus_wr(A_ENCLR, 32'h4);
        bus_rd(A_EN, d, s); check("R7 clear one bit", d, 32'h3);
        bus_wr(A_ENCLR, 32'h3);
    endtask

    task automatic t_soft;
        logic [31:0] d; logic s;
        bus_wr(A_SWT, 32'h10_0000); idle(1);
        bus_rd(A_RAW, d, s); check("R8 soft trigger raw", d & 32'h10_0000, 32'h10_0000);
        check("R7 disabled line masked", {31'b0, irq_o}, 32'd0);
        bus_wr(A_ENSET, 32'h10_0000); idle(1);
        check("R8 soft trigger irq", {31'b0, irq_o}, 32'd1);
        bus_wr(A_CLR, 32'h10_0000); idle(1);
        check("R8 clear drops irq", {31'b0, irq_o}, 32'd0);
        bus_rd(A_SWT, d, s); check("R8 trigger cleared", d, 32'd0);
        bus_wr(A_ENCLR, 32'h10_0000);
    endtask

    task automatic t_legacy;
        logic [31:0] d; logic s;
        bus_wr(LEG | A_ENSET, 32'hFFFF_FFFF);
        bus_rd(A_EN, d, s); check("R9 legacy write no enable", d, 32'd0);
        bus_wr(LEG | A_SWT, 32'hFFFF_FFFF);
        bus_rd(A_RAW, d, s); check("R9 legacy write no trigger", d & 32'hFFFF_FFF0, 32'd0);
        bus_rd(LEG | A_SENSE | HI, d, s);
        check("R9 legacy read zero", d, 32'd0);
        check("R9 legacy ack", {31'b0, s}, 32'd1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_handshake();
        t_rise();
        t_fall();
        t_dual();
        t_level();
        t_enable();
        t_soft();
        t_legacy();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule